// File: doc/BRIEF.md
# Calendar Validator and BCD Codec

This block sits between the date and time values kept in binary on the chip and the packed-BCD byte images that a battery-backed timekeeper stores. In one direction it takes a full four-digit year, a month, a day, an hour, a minute and a second, checks every field against the calendar, and emits six BCD bytes with the year cut down to two digits. Any field that fails its check raises an error flag, and all six bytes are then driven to zero. In the other direction it takes six BCD bytes read back from the timekeeper and returns binary fields. The two-digit year is expanded back to a full year through a fixed hundred-year window.

Both directions are computed combinationally and captured in output registers on a one-cycle input strobe. A done pulse follows one cycle later. The window starts at a parameterised first year (1970 by default), which gives the range 1970 to 2069. The leap-year test applies the full Gregorian rule, including the exceptions for centuries.

Top module: `calendarCodec`

## Requirements
- R1: `packDone` is high exactly in the cycle after `packValid` was sampled high, and `unpackDone` likewise follows `unpackValid`. Between strobes, every registered output holds its value.
- R2: A full year below 1970 or above 2069 sets `packErr`.
- R3: A month of 0 or above 12, or a day of 0, sets `packErr`.
- R4: Month lengths are applied as follows. April, June, September and November have 30 days. February has 28 days. Every other month has 31 days. A day beyond the length of its month sets `packErr`.
- R5: February 29 is accepted only in a leap year. A leap year is divisible by 400, or divisible by 4 and not by 100. For example, 2000 and 2024 are leap years and 2023 is not.
- R6: An hour of 24 or more, a minute of 60 or more, or a second of 60 or more sets `packErr`.
- R7: A valid date is packed with the tens digit in bits 7:4 and the units digit in bits 3:0 of each byte. The stored year is the full year minus 2000 for years from 2000 onward, and minus 1900 for earlier years.
- R8: When `packErr` is set, all six BCD outputs are zero.
- R9: Each readback byte decodes to ten times bits 7:4 plus bits 3:0. A decoded year of 0 to 69 becomes 2000 plus that value, and 70 to 99 becomes 1900 plus that value.
- R10: A nibble greater than 9 in any readback byte sets `unpackErr`.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| packValid | input | 1 | Strobe that captures the binary-to-BCD result |
| inYear | input | 12 | Full binary year |
| inMonth | input | 7 | Binary month, 1 to 12 |
| inDay | input | 7 | Binary day of month |
| inHour | input | 7 | Binary hour |
| inMinute | input | 7 | Binary minute |
| inSecond | input | 7 | Binary second |
| packDone | output | 1 | Pulse one cycle after `packValid` |
| packErr | output | 1 | The captured date or time was rejected |
| bcdYear | output | 8 | Two-digit year, BCD |
| bcdMonth | output | 8 | Month, BCD |
| bcdDay | output | 8 | Day, BCD |
| bcdHour | output | 8 | Hour, BCD |
| bcdMinute | output | 8 | Minute, BCD |
| bcdSecond | output | 8 | Second, BCD |
| unpackValid | input | 1 | Strobe that captures the BCD-to-binary result |
| rdYear | input | 8 | Readback two-digit year, BCD |
| rdMonth | input | 8 | Readback month, BCD |
| rdDay | input | 8 | Readback day, BCD |
| rdHour | input | 8 | Readback hour, BCD |
| rdMinute | input | 8 | Readback minute, BCD |
| rdSecond | input | 8 | Readback second, BCD |
| unpackDone | output | 1 | Pulse one cycle after `unpackValid` |
| unpackErr | output | 1 | A readback nibble was above 9 |
| outYear | output | 12 | Expanded full year |
| outMonth | output | 7 | Decoded month |
| outDay | output | 7 | Decoded day |
| outHour | output | 7 | Decoded hour |
| outMinute | output | 7 | Decoded minute |
| outSecond | output | 7 | Decoded second |

## Verification
The bench probes both ends of the year window: 1969 and 2070 are rejected, 1970 and 2069 are accepted, and the year 2000 is packed as 00. An off-by-one in the window or in the century subtraction would therefore either reject an edge year or store a wrong two-digit value. On the leap side, it tries February 29 in 2000, 2024 and 2023, plus February 30 and April 31. A design with a missing rule for years divisible by 400, or with the 30-day months misplaced, would accept or reject the wrong date. On readback, the pivot values 69 and 70 and out-of-range nibbles in either half of a byte are exercised. A window that is one year off would land in the wrong century, and a digit check that covers only one nibble would miss an illegal byte.

// File: rtl/calCodecPkg.sv
package calCodecPkg;

  // Fields, indexed by position in the internal packed arrays
  localparam int FIELD_N   = 6;
  localparam int IDX_SEC   = 0;
  localparam int IDX_MIN   = 1;
  localparam int IDX_HOUR  = 2;
  localparam int IDX_DAY   = 3;
  localparam int IDX_MONTH = 4;
  localparam int IDX_YEAR  = 5;

  localparam int BCD_W = 8;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadPack;
    logic loadUnpack;
  } calStrobe_t;

endpackage

// File: rtl/calCodecCtrl.sv
module calCodecCtrl
  import calCodecPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       packValid,
  input  logic       unpackValid,
  output calStrobe_t strobe,
  output logic       packDone,
  output logic       unpackDone
);

  always_comb begin
    strobe.loadPack   = packValid;
    strobe.loadUnpack = unpackValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packDone   <= 1'b0;
      unpackDone <= 1'b0;
    end else begin
      packDone   <= packValid;
      unpackDone <= unpackValid;
    end
  end

endmodule

// File: rtl/calCodecPath.sv
module calCodecPath
  import calCodecPkg::*;
#(
  parameter int YEAR_W   = 12,
  parameter int BIN_W    = 7,
  parameter int MIN_YEAR = 1970
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  calStrobe_t                        strobe,
  input  logic [YEAR_W-1:0]                 inYear,
  input  logic [FIELD_N-1:0][BIN_W-1:0]     binIn,
  input  logic [FIELD_N-1:0][BCD_W-1:0]     bcdIn,
  output logic                              packErr,
  output logic [FIELD_N-1:0][BCD_W-1:0]     bcdOut,
  output logic                              unpackErr,
  output logic [YEAR_W-1:0]                 yearOut,
  output logic [FIELD_N-1:0][BIN_W-1:0]     binOut
);

  // Window constants derived from the first accepted year
  localparam int PIVOT    = MIN_YEAR % 100;
  localparam int CENT_LO  = MIN_YEAR - PIVOT;
  localparam int CENT_HI  = CENT_LO + 100;
  localparam int MAX_YEAR = MIN_YEAR + 99;

  localparam logic [YEAR_W-1:0] MIN_V  = YEAR_W'(MIN_YEAR);
  localparam logic [YEAR_W-1:0] MAX_V  = YEAR_W'(MAX_YEAR);
  localparam logic [YEAR_W-1:0] LO_V   = YEAR_W'(CENT_LO);
  localparam logic [YEAR_W-1:0] HI_V   = YEAR_W'(CENT_HI);
  localparam logic [YEAR_W-1:0] Y4     = YEAR_W'(4);
  localparam logic [YEAR_W-1:0] Y100   = YEAR_W'(100);
  localparam logic [YEAR_W-1:0] Y400   = YEAR_W'(400);
  localparam logic [BIN_W-1:0]  PIV_B  = BIN_W'(PIVOT);

  function automatic logic [BIN_W-1:0] monthLen(input logic [BIN_W-1:0] m,
                                                input logic leap);
    case (m)
      BIN_W'(2):  monthLen = leap ? BIN_W'(29) : BIN_W'(28);
      BIN_W'(4),
      BIN_W'(6),
      BIN_W'(9),
      BIN_W'(11): monthLen = BIN_W'(30);
      default:    monthLen = BIN_W'(31);
    endcase
  endfunction

  // ---------------- binary -> BCD ----------------
  logic                          isLeap;
  logic                          yearBad, monthBad, dayBad, timeBad, anyBad;
  logic [YEAR_W-1:0]             shortYear;
  logic [FIELD_N-1:0][BIN_W-1:0] twoDig;
  logic [FIELD_N-1:0][BCD_W-1:0] packBcd;

  always_comb begin
    isLeap = ((inYear % Y4) == '0 && (inYear % Y100) != '0) ||
             ((inYear % Y400) == '0);
    yearBad  = (inYear < MIN_V) || (inYear > MAX_V);
    monthBad = (binIn[IDX_MONTH] == '0) || (binIn[IDX_MONTH] > BIN_W'(12));
    dayBad   = (binIn[IDX_DAY] == '0) ||
               (binIn[IDX_DAY] > monthLen(binIn[IDX_MONTH], isLeap));
    timeBad  = (binIn[IDX_HOUR] >= BIN_W'(24)) ||
               (binIn[IDX_MIN]  >= BIN_W'(60)) ||
               (binIn[IDX_SEC]  >= BIN_W'(60));
    anyBad   = yearBad | monthBad | dayBad | timeBad;
    shortYear = (inYear >= HI_V) ? (inYear - HI_V) : (inYear - LO_V);
  end

  for (genvar g = 0; g < FIELD_N; g++) begin : gPack
    if (g == IDX_YEAR) begin : gYr
      assign twoDig[g] = shortYear[BIN_W-1:0];
    end else begin : gFld
      assign twoDig[g] = binIn[g];
    end
    assign packBcd[g] = {4'(32'(twoDig[g]) / 10), 4'(32'(twoDig[g]) % 10)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packErr <= 1'b0;
      bcdOut  <= '0;
    end else if (strobe.loadPack) begin
      packErr <= anyBad;
      bcdOut  <= anyBad ? '0 : packBcd;
    end
  end

  // ---------------- BCD -> binary ----------------
  logic [FIELD_N-1:0]            digitBad;
  logic [FIELD_N-1:0][BIN_W-1:0] decoded;
  logic [YEAR_W-1:0]             fullYear;

  for (genvar g = 0; g < FIELD_N; g++) begin : gUnpack
    logic [3:0] hiNib, loNib;
    assign hiNib       = bcdIn[g][7:4];
    assign loNib       = bcdIn[g][3:0];
    assign digitBad[g] = (hiNib > 4'd9) || (loNib > 4'd9);
    assign decoded[g]  = BIN_W'(32'(hiNib) * 10 + 32'(loNib));
  end

  always_comb begin
    if (decoded[IDX_YEAR] < PIV_B)
      fullYear = HI_V + YEAR_W'(decoded[IDX_YEAR]);
    else
      fullYear = LO_V + YEAR_W'(decoded[IDX_YEAR]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unpackErr <= 1'b0;
      yearOut   <= '0;
      binOut    <= '0;
    end else if (strobe.loadUnpack) begin
      unpackErr <= |digitBad;
      yearOut   <= fullYear;
      binOut    <= decoded;
    end
  end

endmodule

// File: rtl/calendarCodec.sv
module calendarCodec
  import calCodecPkg::*;
#(
  parameter int YEAR_W   = 12,
  parameter int BIN_W    = 7,
  parameter int MIN_YEAR = 1970
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              packValid,
  input  logic [YEAR_W-1:0] inYear,
  input  logic [BIN_W-1:0]  inMonth,
  input  logic [BIN_W-1:0]  inDay,
  input  logic [BIN_W-1:0]  inHour,
  input  logic [BIN_W-1:0]  inMinute,
  input  logic [BIN_W-1:0]  inSecond,
  output logic              packDone,
  output logic              packErr,
  output logic [7:0]        bcdYear,
  output logic [7:0]        bcdMonth,
  output logic [7:0]        bcdDay,
  output logic [7:0]        bcdHour,
  output logic [7:0]        bcdMinute,
  output logic [7:0]        bcdSecond,
  input  logic              unpackValid,
  input  logic [7:0]        rdYear,
  input  logic [7:0]        rdMonth,
  input  logic [7:0]        rdDay,
  input  logic [7:0]        rdHour,
  input  logic [7:0]        rdMinute,
  input  logic [7:0]        rdSecond,
  output logic              unpackDone,
  output logic              unpackErr,
  output logic [YEAR_W-1:0] outYear,
  output logic [BIN_W-1:0]  outMonth,
  output logic [BIN_W-1:0]  outDay,
  output logic [BIN_W-1:0]  outHour,
  output logic [BIN_W-1:0]  outMinute,
  output logic [BIN_W-1:0]  outSecond
);

  calStrobe_t                    strobe;
  logic [FIELD_N-1:0][BIN_W-1:0] binIn, binOut;
  logic [FIELD_N-1:0][BCD_W-1:0] bcdIn, bcdOut;

  // The year slot of binIn is unused; the full year travels separately
  assign binIn = {BIN_W'(0), inMonth, inDay, inHour, inMinute, inSecond};
  assign bcdIn = {rdYear, rdMonth, rdDay, rdHour, rdMinute, rdSecond};

  assign {bcdYear, bcdMonth, bcdDay, bcdHour, bcdMinute, bcdSecond} = bcdOut;
  assign outMonth  = binOut[IDX_MONTH];
  assign outDay    = binOut[IDX_DAY];
  assign outHour   = binOut[IDX_HOUR];
  assign outMinute = binOut[IDX_MIN];
  assign outSecond = binOut[IDX_SEC];

  calCodecCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .packValid  (packValid),
    .unpackValid(unpackValid),
    .strobe     (strobe),
    .packDone   (packDone),
    .unpackDone (unpackDone)
  );

  calCodecPath #(
    .YEAR_W  (YEAR_W),
    .BIN_W   (BIN_W),
    .MIN_YEAR(MIN_YEAR)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inYear   (inYear),
    .binIn    (binIn),
    .bcdIn    (bcdIn),
    .packErr  (packErr),
    .bcdOut   (bcdOut),
    .unpackErr(unpackErr),
    .yearOut  (outYear),
    .binOut   (binOut)
  );

endmodule

// File: rtl/calendarCodecChk.sv
module calendarCodecChk #(
  parameter int YEAR_W   = 12,
  parameter int BIN_W    = 7,
  parameter int MIN_YEAR = 1970
) (
  input logic              clk,
  input logic              rstN,
  input logic              packValid,
  input logic              packDone,
  input logic              packErr,
  input logic [7:0]        bcdYear,
  input logic [7:0]        bcdMonth,
  input logic [7:0]        bcdDay,
  input logic [7:0]        bcdHour,
  input logic [7:0]        bcdMinute,
  input logic [7:0]        bcdSecond,
  input logic              unpackValid,
  input logic              unpackDone,
  input logic              unpackErr,
  input logic [YEAR_W-1:0] outYear
);

  localparam logic [YEAR_W-1:0] LOW_Y  = YEAR_W'(MIN_YEAR);
  localparam logic [YEAR_W-1:0] HIGH_Y = YEAR_W'(MIN_YEAR + 99);

  logic [47:0] allBcd;
  assign allBcd = {bcdYear, bcdMonth, bcdDay, bcdHour, bcdMinute, bcdSecond};

  function automatic logic legalBcd(input logic [47:0] v);
    legalBcd = 1'b1;
    for (int i = 0; i < 12; i++)
      if (v[i*4 +: 4] > 4'd9) legalBcd = 1'b0;
  endfunction

  assert_pack_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    packValid |=> packDone);

  assert_unpack_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    unpackValid |=> unpackDone);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !packValid |=> ($stable(allBcd) && $stable(packErr)));

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (packDone && packErr) |-> (allBcd == 48'h0));

  assert_legal_digits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (packDone && !packErr) |-> legalBcd(allBcd));

  assert_year_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    (unpackDone && !unpackErr) |-> (outYear >= LOW_Y && outYear <= HIGH_Y));

endmodule

bind calendarCodec calendarCodecChk #(
  .YEAR_W  (YEAR_W),
  .BIN_W   (BIN_W),
  .MIN_YEAR(MIN_YEAR)
) i_calendarCodecChk (
  .clk        (clk),
  .rstN       (rstN),
  .packValid  (packValid),
  .packDone   (packDone),
  .packErr    (packErr),
  .bcdYear    (bcdYear),
  .bcdMonth   (bcdMonth),
  .bcdDay     (bcdDay),
  .bcdHour    (bcdHour),
  .bcdMinute  (bcdMinute),
  .bcdSecond  (bcdSecond),
  .unpackValid(unpackValid),
  .unpackDone (unpackDone),
  .unpackErr  (unpackErr),
  .outYear    (outYear)
);

// File: tb/test_calendarCodec.sv
`timescale 1ns/1ps
module test_calendarCodec;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        packValid = 1'b0;
  logic [11:0] inYear = '0;
  logic [6:0]  inMonth = '0, inDay = '0, inHour = '0, inMinute = '0, inSecond = '0;
  logic        packDone, packErr;
  logic [7:0]  bcdYear, bcdMonth, bcdDay, bcdHour, bcdMinute, bcdSecond;
  logic        unpackValid = 1'b0;
  logic [7:0]  rdYear = '0, rdMonth = '0, rdDay = '0, rdHour = '0, rdMinute = '0, rdSecond = '0;
  logic        unpackDone, unpackErr;
  logic [11:0] outYear;
  logic [6:0]  outMonth, outDay, outHour, outMinute, outSecond;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  calendarCodec i_calendarCodec (
    .clk(clk), .rstN(rstN),
    .packValid(packValid), .inYear(inYear), .inMonth(inMonth), .inDay(inDay),
    .inHour(inHour), .inMinute(inMinute), .inSecond(inSecond),
    .packDone(packDone), .packErr(packErr),
    .bcdYear(bcdYear), .bcdMonth(bcdMonth), .bcdDay(bcdDay),
    .bcdHour(bcdHour), .bcdMinute(bcdMinute), .bcdSecond(bcdSecond),
    .unpackValid(unpackValid), .rdYear(rdYear), .rdMonth(rdMonth), .rdDay(rdDay),
    .rdHour(rdHour), .rdMinute(rdMinute), .rdSecond(rdSecond),
    .unpackDone(unpackDone), .unpackErr(unpackErr),
    .outYear(outYear), .outMonth(outMonth), .outDay(outDay),
    .outHour(outHour), .outMinute(outMinute), .outSecond(outSecond)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] bcdAll();
    return {bcdYear, bcdMonth, bcdDay, bcdHour, bcdMinute, bcdSecond};
  endfunction

  // Pack one date; expBcd holds year,month,day,hour,minute,second bytes
  task automatic tPack(input string req, input int y, input int mo, input int d,
                       input int h, input int mi, input int s,
                       input logic expErr, input logic [47:0] expBcd);
    @(negedge clk);
    inYear = 12'(y); inMonth = 7'(mo); inDay = 7'(d);
    inHour = 7'(h); inMinute = 7'(mi); inSecond = 7'(s);
    packValid = 1'b1;
    @(negedge clk);
    packValid = 1'b0;
    chk({req, " done"}, 64'(packDone), 64'(1));
    chk({req, " err"}, 64'(packErr), 64'(expErr));
    chk({req, " bcd"}, 64'(bcdAll()), 64'(expBcd));
  endtask

  task automatic tUnpack(input string req, input logic [47:0] bytes, input logic expErr,
                         input int ey, input int emo, input int ed,
                         input int eh, input int emi, input int es);
    @(negedge clk);
    {rdYear, rdMonth, rdDay, rdHour, rdMinute, rdSecond} = bytes;
    unpackValid = 1'b1;
    @(negedge clk);
    unpackValid = 1'b0;
    chk({req, " done"}, 64'(unpackDone), 64'(1));
    chk({req, " err"}, 64'(unpackErr), 64'(expErr));
    if (!expErr) begin
      chk({req, " year"}, 64'(outYear), 64'(ey));
      chk({req, " fields"}, 64'({outMonth, outDay, outHour, outMinute, outSecond}),
          64'({7'(emo), 7'(ed), 7'(eh), 7'(emi), 7'(es)}));
    end
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    chk("R11 reset pack", 64'({packDone, packErr, bcdAll()}), 64'(0));
    chk("R11 reset unpack", 64'({unpackDone, unpackErr, outYear, outMonth, outDay,
                                 outHour, outMinute, outSecond}), 64'(0));
    rstN = 1'b1;
  endtask

  task automatic tHold();
    tPack("R1 base", 2024, 2, 29, 23, 59, 58, 1'b0, 48'h24_02_29_23_59_58);
    @(negedge clk);
    chk("R1 done pulse ends", 64'(packDone), 64'(0));
    inYear = 12'd1800; inMonth = 7'd0; inSecond = 7'd99;
    repeat (3) @(negedge clk);
    chk("R1 hold bcd", 64'(bcdAll()), 64'h24_02_29_23_59_58);
    chk("R1 hold err", 64'(packErr), 64'(0));
    tUnpack("R1 unpack base", 48'h05_07_04_10_20_30, 1'b0, 2005, 7, 4, 10, 20, 30);
    @(negedge clk);
    chk("R1 unpack pulse ends", 64'(unpackDone), 64'(0));
  endtask

  task automatic tYears();
    tPack("R7 1970", 1970, 1, 1, 0, 0, 0, 1'b0, 48'h70_01_01_00_00_00);
    tPack("R7 1999", 1999, 12, 31, 23, 59, 59, 1'b0, 48'h99_12_31_23_59_59);
    tPack("R7 2000", 2000, 3, 15, 8, 5, 9, 1'b0, 48'h00_03_15_08_05_09);
    tPack("R7 2069", 2069, 6, 15, 12, 30, 45, 1'b0, 48'h69_06_15_12_30_45);
    tPack("R2 1969", 1969, 6, 1, 0, 0, 0, 1'b1, 48'h0);
    tPack("R2 2070", 2070, 6, 1, 0, 0, 0, 1'b1, 48'h0);
  endtask

  task automatic tDates();
    tPack("R3 month0", 2010, 0, 1, 0, 0, 0, 1'b1, 48'h0);
    tPack("R3 month13", 2010, 13, 1, 0, 0, 0, 1'b1, 48'h0);
    tPack("R3 day0", 2010, 5, 0, 0, 0, 0, 1'b1, 48'h0);
    tPack("R4 apr31", 2010, 4, 31, 0, 0, 0, 1'b1, 48'h0);
    tPack("R4 apr30", 2010, 4, 30, 0, 0, 0, 1'b0, 48'h10_04_30_00_00_00);
    tPack("R4 nov31", 2010, 11, 31, 0, 0, 0, 1'b1, 48'h0);
    tPack("R4 aug31", 2010, 8, 31, 0, 0, 0, 1'b0, 48'h10_08_31_00_00_00);
    tPack("R5 feb29 2023", 2023, 2, 29, 0, 0, 0, 1'b1, 48'h0);
    tPack("R5 feb28 2023", 2023, 2, 28, 0, 0, 0, 1'b0, 48'h23_02_28_00_00_00);
    tPack("R5 feb29 2000", 2000, 2, 29, 0, 0, 0, 1'b0, 48'h00_02_29_00_00_00);
    tPack("R5 feb30 2024", 2024, 2, 30, 0, 0, 0, 1'b1, 48'h0);
  endtask

  task automatic tTimes();
    tPack("R6 hour24", 2010, 1, 1, 24, 0, 0, 1'b1, 48'h0);
    tPack("R6 min60", 2010, 1, 1, 0, 60, 0, 1'b1, 48'h0);
    tPack("R6 sec60", 2010, 1, 1, 0, 0, 60, 1'b1, 48'h0);
    tPack("R7 max time", 2010, 1, 1, 23, 59, 59, 1'b0, 48'h10_01_01_23_59_59);
    // R8: an error after a good result must clear all bytes
    tPack("R8 clear", 2010, 1, 32, 1, 1, 1, 1'b1, 48'h0);
  endtask

  task automatic tReadback();
    tUnpack("R9 yy69", 48'h69_12_31_23_59_59, 1'b0, 2069, 12, 31, 23, 59, 59);
    tUnpack("R9 yy70", 48'h70_01_01_00_00_00, 1'b0, 1970, 1, 1, 0, 0, 0);
    tUnpack("R9 yy00", 48'h00_02_29_11_45_07, 1'b0, 2000, 2, 29, 11, 45, 7);
    tUnpack("R9 yy99", 48'h99_09_18_19_38_27, 1'b0, 1999, 9, 18, 19, 38, 27);
    tUnpack("R10 low nibble", 48'h20_1A_01_00_00_00, 1'b1, 0, 0, 0, 0, 0, 0);
    tUnpack("R10 high nibble", 48'h20_01_01_00_00_A0, 1'b1, 0, 0, 0, 0, 0, 0);
    tUnpack("R10 year F9", 48'hF9_01_01_00_00_00, 1'b1, 0, 0, 0, 0, 0, 0);
    tUnpack("R10 clean again", 48'h45_06_07_08_09_10, 1'b0, 2045, 6, 7, 8, 9, 10);
  endtask

  initial begin
    tReset();
    tHold();
    tYears();
    tDates();
    tTimes();
    tReadback();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule